// File: doc/BRIEF.md
# Burst Back Porch Gate Generator

This block watches an already-sampled, active-low composite sync signal. After each trailing (rising) edge of that signal it produces a low-going gate that marks the back porch, where the colour burst sits. The gate waits a fixed number of clock cycles after the edge and then stays low for a fixed number of cycles. Both counts are elaboration-time parameters, so one clock rate and one video standard give one pair of values. For example, at 20 MHz, 4 cycles of delay give 200 ns and 70 cycles of width give 3.5 us.

Every rising edge of sync starts a gate. This covers ordinary line sync pulses, equalizing pulses, and the short high-going serration gaps inside the vertical interval. In that interval the gate follows the rising edge of each serration. A new edge that arrives while a gate is still pending or active abandons the old sequence and starts again from the new edge.

Top module: `porch_gate_gen`

## Requirements
- R1: After a cycle with `rst` high, `gate_n` is high. It stays high until a rising edge of `csync_n` has been seen.
- R2: A rising edge is a clock edge at which `csync_n` is sampled 1 after being sampled 0 at the previous clock edge. `gate_n` is first low on the clock edge `DELAY_CYC` cycles after that sampling edge.
- R3: Once low, `gate_n` stays low for exactly `WIDTH_CYC` clock cycles and then returns high, unless R5 or R6 applies.
- R4: A falling edge of `csync_n`, or a steady level of either value, starts no gate and leaves `gate_n` unchanged.
- R5: A rising edge during the delay phase restarts the delay from the new edge. The gate then starts `DELAY_CYC` cycles after the newer edge.
- R6: A rising edge during the low phase ends it. `gate_n` is high for the delay that follows the new edge, then low for a full `WIDTH_CYC` cycles.
- R7: In a train of pulses, each rising edge gives its own complete gate. This holds both for mostly-high pulses (equalizing) and for mostly-low pulses with short high gaps (serration).
- R8: With `DELAY_CYC` = 0, `gate_n` is low on the same clock edge that samples the rising edge. A rising edge during the low phase keeps `gate_n` low and gives a fresh `WIDTH_CYC` window.
- R9: The internal cycle counter stays within its loaded range and never wraps below zero.
- R10: `gate_n` is low only while the gate phase is active. It idles high whenever no sequence is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Sampled composite sync, low during sync pulses |
| gate_n | output | 1 | Back porch gate, low during the burst window |

## Verification
Counted from the clock edge that samples a rising edge of `csync_n`, `gate_n` falls `DELAY_CYC` edges later and rises again `DELAY_CYC + WIDTH_CYC` edges later. With the input driven on a falling clock edge, those transitions become visible at falling edge `DELAY_CYC + 1` and falling edge `DELAY_CYC + WIDTH_CYC + 1`. Each scenario task compares `gate_n` at every falling edge of its window against that expected profile, which is computed from the two parameters alone. Scenarios that restart the sequence take their window from the most recent edge. A second instance with zero delay and a short width covers the zero-delay case.

// File: rtl/porch_gate_pkg.sv
package porch_gate_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_WAIT = 2'd1,
    PG_GATE = 2'd2
  } pg_state_e;

  function automatic int unsigned pg_cnt_width(input int unsigned max_cnt);
    if (max_cnt < 3) return 1;
    return $clog2(max_cnt);
  endfunction

endpackage

// File: rtl/pg_edge_detect.sv
module pg_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= csync_n;
  end

  assign rise = csync_n & ~prev_q;

  // R2: a rise needs a low sample before it, so two rises cannot be adjacent
  p_no_double_rise_r2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
  import porch_gate_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 4,
  parameter int unsigned WIDTH_CYC = 70
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      rise,
  output pg_state_e state,
  output logic      gate_next
);
  localparam int unsigned MAX_CNT = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
  localparam int unsigned CNT_W   = pg_cnt_width(MAX_CNT);
  localparam logic [CNT_W-1:0] WID_LOAD = CNT_W'((WIDTH_CYC > 0) ? WIDTH_CYC - 1 : 0);
  localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'((DELAY_CYC > 0) ? DELAY_CYC - 1 : 0);

  pg_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pg_state_e        start_state;
  logic [CNT_W-1:0] start_load;

  generate
    if (DELAY_CYC == 0) begin : g_no_delay
      assign start_state = PG_GATE;
      assign start_load  = WID_LOAD;
    end else begin : g_delay
      assign start_state = PG_WAIT;
      assign start_load  = DLY_LOAD;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (rise) begin
      state_d = start_state;
      cnt_d   = start_load;
    end else begin
      unique case (state_q)
        PG_WAIT: begin
          if (cnt_q == '0) begin
            state_d = PG_GATE;
            cnt_d   = WID_LOAD;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PG_GATE: begin
          if (cnt_q == '0) state_d = PG_IDLE;
          else             cnt_d   = cnt_q - 1'b1;
        end
        default: begin
          state_d = PG_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PG_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state     = state_q;
  assign gate_next = (state_d == PG_GATE);

  // R9: counter bounded by the largest load, never wraps
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= CNT_W'(MAX_CNT - 1)));
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != PG_IDLE && cnt_q == '0 && !rise) |=> (cnt_q == '0 || state_q == PG_GATE));
  // R3: expiry of the gate phase returns to idle
  p_gate_end_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == PG_GATE && cnt_q == '0 && !rise) |=> (state_q == PG_IDLE));
  // R5: any rise leaves the machine busy
  p_rise_starts_r5: assert property (@(posedge clk) disable iff (rst)
    rise |=> (state_q != PG_IDLE));

endmodule

// File: rtl/pg_out_reg.sv
module pg_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic gate_next,
  output logic gate_n
);
  always_ff @(posedge clk) begin
    if (rst) gate_n <= 1'b1;
    else     gate_n <= ~gate_next;
  end

  // R1: output is high in the first cycle after reset
  p_reset_high_r1: assert property (@(posedge clk)
    $past(rst) |-> gate_n);

endmodule

// File: rtl/porch_gate_gen.sv
module porch_gate_gen
  import porch_gate_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 4,
  parameter int unsigned WIDTH_CYC = 70
) (
  input  logic clk,
  input  logic rst,
  input  logic csync_n,
  output logic gate_n
);
  logic      rise;
  logic      gate_next;
  pg_state_e seq_state;

  pg_edge_detect u_edge (
    .clk     (clk),
    .rst     (rst),
    .csync_n (csync_n),
    .rise    (rise)
  );

  pg_sequencer #(
    .DELAY_CYC (DELAY_CYC),
    .WIDTH_CYC (WIDTH_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .state     (seq_state),
    .gate_next (gate_next)
  );

  pg_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .gate_next (gate_next),
    .gate_n    (gate_n)
  );

  // R10: low output only while the gate phase is active
  p_low_in_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !gate_n |-> (seq_state == PG_GATE));
  // R4: idle without a rise keeps the output high
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_state == PG_IDLE && !rise) |=> gate_n);

endmodule

// File: tb/porch_gate_gen_tb.sv
module porch_gate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int W  = 70;
  localparam int DZ = 0;
  localparam int WZ = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csync_n = 1'b1;
  logic gate_n, gate_z_n;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  porch_gate_gen #(.DELAY_CYC(D), .WIDTH_CYC(W)) u_dut (
    .clk(clk), .rst(rst), .csync_n(csync_n), .gate_n(gate_n));

  porch_gate_gen #(.DELAY_CYC(DZ), .WIDTH_CYC(WZ)) u_dut_z (
    .clk(clk), .rst(rst), .csync_n(csync_n), .gate_n(gate_z_n));

  task automatic check_bit(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Step through falling edges 1..first+len after a drive; low expected in [first, first+len)
  task automatic expect_gate(input int first, input int len, input bit use_z, input string req);
    for (int i = 1; i <= first + len; i++) begin
      @(negedge clk);
      check_bit(use_z ? gate_z_n : gate_n, (i >= first && i < first + len) ? 1'b0 : 1'b1,
                req, $sformatf("edge %0d", i));
    end
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_bit(gate_n, 1'b1, req, "idle main");
      check_bit(gate_z_n, 1'b1, req, "idle zero-delay");
    end
  endtask

  task automatic t_reset_r1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(10, "R1");
  endtask

  task automatic t_fall_level_r4;
    csync_n = 1'b0;
    idle(20, "R4");
  endtask

  task automatic t_single_r2_r3;
    csync_n = 1'b1;
    expect_gate(D + 1, W, 1'b0, "R2/R3");
    idle(30, "R10");
  endtask

  task automatic t_retrig_delay_r5;
    csync_n = 1'b0;
    repeat (10) @(negedge clk);
    csync_n = 1'b1;
    @(negedge clk);
    check_bit(gate_n, 1'b1, "R5", "delay phase");
    csync_n = 1'b0;
    @(negedge clk);
    check_bit(gate_n, 1'b1, "R5", "delay phase");
    csync_n = 1'b1;
    expect_gate(D + 1, W, 1'b0, "R5");
    idle(20, "R10");
  endtask

  task automatic t_retrig_gate_r6;
    csync_n = 1'b0;
    repeat (10) @(negedge clk);
    csync_n = 1'b1;
    repeat (20) @(negedge clk);
    check_bit(gate_n, 1'b0, "R6", "mid gate");
    csync_n = 1'b0;
    @(negedge clk);
    check_bit(gate_n, 1'b0, "R6", "mid gate");
    csync_n = 1'b1;
    expect_gate(D + 1, W, 1'b0, "R6");
    idle(20, "R10");
  endtask

  task automatic t_equalizing_r7;
    for (int p = 0; p < 3; p++) begin
      csync_n = 1'b0;
      repeat (10) @(negedge clk);
      csync_n = 1'b1;
      expect_gate(D + 1, W, 1'b0, "R7 equalizing");
      repeat (15) @(negedge clk);
    end
  endtask

  task automatic t_serration_r7;
    csync_n = 1'b0;
    repeat (20) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      csync_n = 1'b1;
      fork
        expect_gate(D + 1, W, 1'b0, "R7 serration");
        begin
          repeat (12) @(negedge clk);
          csync_n = 1'b0;
        end
      join
      repeat (10) @(negedge clk);
    end
    csync_n = 1'b1;
    repeat (D + W + 5) @(negedge clk);
    idle(5, "R10");
  endtask

  task automatic t_zero_delay_r8;
    csync_n = 1'b0;
    repeat (5) @(negedge clk);
    csync_n = 1'b1;
    expect_gate(1, WZ, 1'b1, "R8");
    repeat (D + W) @(negedge clk);
    csync_n = 1'b0;
    repeat (5) @(negedge clk);
    csync_n = 1'b1;
    @(negedge clk);
    check_bit(gate_z_n, 1'b0, "R8", "first gate");
    csync_n = 1'b0;
    @(negedge clk);
    check_bit(gate_z_n, 1'b0, "R8", "first gate");
    csync_n = 1'b1;
    expect_gate(1, WZ, 1'b1, "R8 retrigger");
    repeat (D + W) @(negedge clk);
  endtask

  initial begin
    t_reset_r1();
    t_fall_level_r4();
    t_single_r2_r3();
    t_retrig_delay_r5();
    t_retrig_gate_r6();
    t_equalizing_r7();
    t_serration_r7();
    t_zero_delay_r8();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule